// File: doc/BRIEF.md
# Polled Character Terminal Port

This block connects a processor's byte bus to a keyboard and a display. Each side has a one-character holding register and a ready flag. Software finds out whether work is waiting by polling a status byte. The keyboard presents a character together with a one-cycle strobe. The block latches the character and raises the input-ready flag.

On the display side, software writes a character into the output register. That write clears the output-ready flag and starts a valid/acknowledge transfer toward the display. When the display accepts the character, the flag comes back.

Both ready flags sit in the most significant bit of their status bytes, so a sign test on a status read is enough to poll them. The flags are cleared by bus traffic alone: a read of the input character clears the input flag, and a write of the output character clears the output flag. Software never writes the flags directly.

Top module: `cio_port`

## Requirements
- R1: After reset the input status byte reads 0x00, the output status byte reads 0x80 and `dsp_valid` is low.
- R2: A cycle with `kbd_stb` high loads `kbd_char` into the input register. From the next cycle, bit 7 of the input status byte is 1 and a read of address 0 returns that character.
- R3: A read of address 0 clears the input-ready flag from the next cycle on. If `kbd_stb` is high in the same cycle as that read, the new character is loaded and the flag stays 1.
- R4: A write to address 2 while the output-ready flag is 1 has three effects from the next cycle: the written byte appears on `dsp_char`, `dsp_valid` goes high, and bit 7 of the output status byte reads 0.
- R5: A cycle in which `dsp_ack` and `dsp_valid` are both high drops `dsp_valid`, and the output-ready flag reads 1 in the following cycle.
- R6: A `kbd_stb` while the input-ready flag is 1, in a cycle with no read of address 0, overwrites the input register and sets the overrun bit, bit 0 of the input status byte. The bit stays set until a read of address 1. That read still returns the bit as 1, and the bit reads 0 afterwards. If a strobe that would set the bit coincides with a read of address 1, the set wins.
- R7: A write to address 2 while the output-ready flag is 0 is ignored: `dsp_char`, `dsp_valid` and the output register are unchanged.
- R8: Status bits other than the ready flag (bit 7) and the overrun bit (bit 0 of the input status only) read 0. Writes to addresses 0, 1 and 3 change no state. `bus_rdata` is 0 whenever no read is in progress.
- R9: Address map: 0 is the input character, 1 the input status, 2 the output character (a read returns the last accepted write), 3 the output status. Read data is combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| kbd_stb | input | 1 | Keyboard character strobe |
| kbd_char | input | 8 | Keyboard character |
| dsp_char | output | 8 | Character presented to the display |
| dsp_valid | output | 1 | Display transfer pending |
| dsp_ack | input | 1 | Display accepts the pending character |

## Verification
The assertions assume that every input is at a known level once reset is released. They also assume the display raises `dsp_ack` only while a transfer is pending. An acknowledge outside a transfer would be ignored by the design, but the property set does not cover that case. The random stimulus keeps to this by driving `dsp_ack` only in cycles where the bench's own model has a pending transfer. The bus address, direction, data and keyboard strobe are drawn freely, so same-cycle collisions between strobes, reads and writes occur often.

// File: rtl/cio_pkg.sv
package cio_pkg;

    localparam int unsigned CIO_DW   = 8;
    localparam int unsigned CIO_AW   = 2;
    localparam int unsigned FLAG_BIT = CIO_DW - 1;
    localparam int unsigned OVR_BIT  = 0;

    typedef logic [CIO_DW-1:0] cio_byte_t;

    typedef enum logic [CIO_AW-1:0] {
        REG_KBD_DATA = 2'd0,
        REG_KBD_STAT = 2'd1,
        REG_DSP_DATA = 2'd2,
        REG_DSP_STAT = 2'd3
    } cio_reg_e;

    typedef struct packed {
        cio_byte_t chr;
        logic      full;
        logic      ovr;
    } kbd_state_t;

    typedef struct packed {
        cio_byte_t chr;
        logic      ready;
        logic      busy;
    } dsp_state_t;

    typedef struct packed {
        logic rd_kdata;
        logic rd_kstat;
        logic wr_ddata;
    } bus_evt_t;

endpackage

// File: rtl/cio_bus_decode.sv
module cio_bus_decode
    import cio_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CIO_AW-1:0] bus_addr,
    input  cio_byte_t         kbd_chr,
    input  logic              kbd_full,
    input  logic              kbd_ovr,
    input  cio_byte_t         dsp_chr,
    input  logic              dsp_ready,
    output bus_evt_t          evt,
    output cio_byte_t         rdata
);

    always_comb begin
        evt   = '0;
        rdata = '0;
        if (bus_sel) begin
            case (cio_reg_e'(bus_addr))
                REG_KBD_DATA: begin
                    if (!bus_wr) begin
                        evt.rd_kdata = 1'b1;
                        rdata        = kbd_chr;
                    end
                end
                REG_KBD_STAT: begin
                    if (!bus_wr) begin
                        evt.rd_kstat      = 1'b1;
                        rdata[FLAG_BIT]   = kbd_full;
                        rdata[OVR_BIT]    = kbd_ovr;
                    end
                end
                REG_DSP_DATA: begin
                    if (bus_wr) begin
                        evt.wr_ddata = 1'b1;
                    end else begin
                        rdata = dsp_chr;
                    end
                end
                REG_DSP_STAT: begin
                    if (!bus_wr) begin
                        rdata[FLAG_BIT] = dsp_ready;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/cio_kbd_buf.sv
module cio_kbd_buf
    import cio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      kbd_stb,
    input  cio_byte_t kbd_char,
    input  logic      rd_data,
    input  logic      rd_stat,
    output cio_byte_t chr,
    output logic      full,
    output logic      ovr
);

    kbd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // reading the character consumes it
        if (rd_data) begin
            st_d.full = 1'b0;
        end
        // reading status acknowledges a past overrun
        if (rd_stat) begin
            st_d.ovr = 1'b0;
        end
        // a new character always lands; losing an unread one is recorded
        if (kbd_stb) begin
            st_d.chr  = kbd_char;
            st_d.full = 1'b1;
            if (st_q.full && !rd_data) begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chr  = st_q.chr;
    assign full = st_q.full;
    assign ovr  = st_q.ovr;

endmodule

// File: rtl/cio_dsp_buf.sv
module cio_dsp_buf
    import cio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_data,
    input  cio_byte_t wdata,
    input  logic      disp_ack,
    output cio_byte_t chr,
    output logic      ready,
    output logic      busy
);

    dsp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // accepted only when the previous character has been taken
        if (wr_data && st_q.ready) begin
            st_d.chr   = wdata;
            st_d.ready = 1'b0;
            st_d.busy  = 1'b1;
        end
        if (st_q.busy && disp_ack) begin
            st_d.busy  = 1'b0;
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chr   <= '0;
            st_q.ready <= 1'b1;
            st_q.busy  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chr   = st_q.chr;
    assign ready = st_q.ready;
    assign busy  = st_q.busy;

endmodule

// File: rtl/cio_port.sv
module cio_port
    import cio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CIO_AW-1:0] bus_addr,
    input  logic [CIO_DW-1:0] bus_wdata,
    output logic [CIO_DW-1:0] bus_rdata,
    input  logic              kbd_stb,
    input  logic [CIO_DW-1:0] kbd_char,
    output logic [CIO_DW-1:0] dsp_char,
    output logic              dsp_valid,
    input  logic              dsp_ack
);

    bus_evt_t  evt;
    cio_byte_t kbd_chr;
    logic      kbd_full;
    logic      kbd_ovr;
    logic      dsp_ready;

    cio_bus_decode u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .kbd_chr   (kbd_chr),
        .kbd_full  (kbd_full),
        .kbd_ovr   (kbd_ovr),
        .dsp_chr   (dsp_char),
        .dsp_ready (dsp_ready),
        .evt       (evt),
        .rdata     (bus_rdata)
    );

    cio_kbd_buf u_kbd (
        .clk      (clk),
        .rst_n    (rst_n),
        .kbd_stb  (kbd_stb),
        .kbd_char (kbd_char),
        .rd_data  (evt.rd_kdata),
        .rd_stat  (evt.rd_kstat),
        .chr      (kbd_chr),
        .full     (kbd_full),
        .ovr      (kbd_ovr)
    );

    cio_dsp_buf u_dsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (evt.wr_ddata),
        .wdata    (bus_wdata),
        .disp_ack (dsp_ack),
        .chr      (dsp_char),
        .ready    (dsp_ready),
        .busy     (dsp_valid)
    );

endmodule

// File: rtl/cio_port_chk.sv
module cio_port_chk
    import cio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [CIO_AW-1:0] bus_addr,
    input logic [CIO_DW-1:0] bus_wdata,
    input logic [CIO_DW-1:0] bus_rdata,
    input logic              kbd_stb,
    input logic [CIO_DW-1:0] kbd_char,
    input logic [CIO_DW-1:0] dsp_char,
    input logic              dsp_valid,
    input logic              dsp_ack,
    input logic [CIO_DW-1:0] kbd_chr,
    input logic              kbd_full,
    input logic              kbd_ovr,
    input logic              dsp_ready
);

    logic rd_in_data, rd_out_stat, wr_out_data;
    assign rd_in_data  = bus_sel && !bus_wr && (bus_addr == 2'd0);
    assign rd_out_stat = bus_sel && !bus_wr && (bus_addr == 2'd3);
    assign wr_out_data = bus_sel &&  bus_wr && (bus_addr == 2'd2);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_stb |=> kbd_full && (kbd_chr == $past(kbd_char)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_in_data && !kbd_stb |=> !kbd_full);

    p_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out_data && dsp_ready |=> dsp_valid && !dsp_ready && (dsp_char == $past(bus_wdata)));

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsp_valid && dsp_ready));

    p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid && dsp_ack |=> dsp_ready && !dsp_valid);

    p_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_full && kbd_stb && !rd_in_data |=> kbd_ovr);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid && !dsp_ack |=> dsp_valid && $stable(dsp_char));

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));

    p_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_stat |-> (bus_rdata[FLAG_BIT-1:0] == '0) && (bus_rdata[FLAG_BIT] == dsp_ready));

endmodule

bind cio_port cio_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .kbd_stb   (kbd_stb),
    .kbd_char  (kbd_char),
    .dsp_char  (dsp_char),
    .dsp_valid (dsp_valid),
    .dsp_ack   (dsp_ack),
    .kbd_chr   (kbd_chr),
    .kbd_full  (kbd_full),
    .kbd_ovr   (kbd_ovr),
    .dsp_ready (dsp_ready)
);

// File: tb/tb_cio_port.sv
`timescale 1ns/1ps
module tb_cio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       kbd_stb = 1'b0;
    logic [7:0] kbd_char = '0;
    logic [7:0] dsp_char;
    logic       dsp_valid;
    logic       dsp_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the requirements
    logic [7:0] m_in = '0, m_out = '0;
    logic       m_full = 1'b0, m_ovr = 1'b0, m_ready = 1'b1, m_busy = 1'b0;

    always #2.5 clk = ~clk;

    cio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_stb(kbd_stb), .kbd_char(kbd_char), .dsp_char(dsp_char),
        .dsp_valid(dsp_valid), .dsp_ack(dsp_ack)
    );

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_in;
            2'd1:    return {m_full, 6'b0, m_ovr};
            2'd2:    return m_out;
            default: return {m_ready, 7'b0};
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus/device cycle; entered just after a falling edge
    task automatic cyc(input logic sel, input logic wr, input logic [1:0] addr,
                       input logic [7:0] wd, input logic stb, input logic [7:0] ch,
                       input logic ack, input string tag);
        logic rk, rs, wd2, old_full, old_busy;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        kbd_stb = stb; kbd_char = ch; dsp_ack = ack;
        #1;
        if (sel && !wr) chk(bus_rdata, exp_rd(addr), tag);
        else chk(bus_rdata, 8'h00, "R8 idle rdata");
        chk({7'b0, dsp_valid}, {7'b0, m_busy}, "R5 dsp_valid");
        if (m_busy) chk(dsp_char, m_out, "R4 dsp_char");
        @(posedge clk);
        rk  = sel && !wr && addr == 2'd0;
        rs  = sel && !wr && addr == 2'd1;
        wd2 = sel &&  wr && addr == 2'd2;
        old_full = m_full;
        old_busy = m_busy;
        if (rk) m_full = 1'b0;
        if (rs) m_ovr = 1'b0;
        if (stb) begin
            if (old_full && !rk) m_ovr = 1'b1;
            m_full = 1'b1;
            m_in = ch;
        end
        if (wd2 && m_ready) begin
            m_out = wd; m_ready = 1'b0; m_busy = 1'b1;
        end
        if (old_busy && ack) begin
            m_busy = 1'b0; m_ready = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'd24680);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk(bus_rdata, 8'h00, "R1 idle");
        rd(2'd1, "R1 in status");
        rd(2'd3, "R1 out status");

        // R2 load, R3 clear on read
        cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h41, 1'b0, "R2");
        chk(exp_rd(2'd1), 8'h80, "R2 model");
        rd(2'd1, "R2 in status after strobe");
        rd(2'd0, "R2 R9 in data");
        rd(2'd1, "R3 flag cleared");

        // R6 overrun, sticky until status read
        cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h10, 1'b0, "R6");
        cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h20, 1'b0, "R6");
        rd(2'd0, "R6 overwritten char");
        rd(2'd1, "R6 overrun bit reads 1");
        rd(2'd1, "R6 overrun cleared");

        // R3 strobe coincident with data read
        cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h31, 1'b0, "R3");
        cyc(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h32, 1'b0, "R3 read with strobe");
        rd(2'd1, "R3 flag kept, no overrun");
        rd(2'd0, "R3 new char");

        // R4 send, R7 ignored write, R5 acknowledge
        cyc(1'b1, 1'b1, 2'd2, 8'h55, 1'b0, 8'h00, 1'b0, "R4");
        rd(2'd3, "R4 out status busy");
        cyc(1'b1, 1'b1, 2'd2, 8'h66, 1'b0, 8'h00, 1'b0, "R7");
        rd(2'd2, "R7 R9 out data unchanged");
        cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1, "R5");
        rd(2'd3, "R5 out status ready");

        // R8 writes to other addresses are ignored
        cyc(1'b1, 1'b1, 2'd0, 8'hFF, 1'b0, 8'h00, 1'b0, "R8");
        cyc(1'b1, 1'b1, 2'd1, 8'hFF, 1'b0, 8'h00, 1'b0, "R8");
        cyc(1'b1, 1'b1, 2'd3, 8'h00, 1'b0, 8'h00, 1'b0, "R8");
        rd(2'd0, "R8 in data");
        rd(2'd1, "R8 in status");
        rd(2'd3, "R8 out status");

        // random traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic s, w, k, a;
            s = ($urandom % 4) != 0;
            w = ($urandom % 3) == 0;
            k = ($urandom % 5) == 0;
            a = m_busy && ($urandom % 2);
            cyc(s, w, 2'($urandom % 4), 8'($urandom), k, 8'($urandom), a, "R9 random");
        end

        finish_run();
    end

endmodule